// File: doc/BRIEF.md
# Hysteretic Auto-Restart Supervisor

This block is the digital sequencer that sits beside the supply-rail capacitor of a switching power stage. It takes two comparator flags from the rail: one that says the rail is above its upper threshold and one that says it is below its lower threshold. It drives two outputs. One enables the high-voltage bias current source that charges the rail. The other enables the pulse-width modulator and the output switch. At start-up the bias source charges the rail. The first upper-threshold crossing hands over to normal switching, and from then on the bias source stays off.

If the rail sags to the lower threshold, or loss of regulation is flagged, switching stops and the block enters auto-restart. In auto-restart the bias source toggles hysteretically: it turns on at the lower threshold and off at the upper threshold. A skip counter lets switching resume for a single retry only after a fixed number of discharge-charge cycles, eight by default. If regulation has returned by then, the block stays in normal operation. Otherwise the cycle repeats.

An overvoltage pulse or an over-temperature flag sets a sticky fault latch. Each cause has its own latch. A set latch holds switching off, while the rail stays in hysteretic regulation. Only a power-up reset clears the latches, and a power-up reset overrides every other input.

Top module: `hyst_restart_sup`

## Requirements
- R1: When `rst` or `por` is sampled high, both outputs are low in the following cycle (idle state). One cycle after the reset ends, `bias_en` is 1 and `sw_en` is 0 (start-up charging).
- R2: During start-up, `rail_lo` and `reg_lost` are ignored. The cycle after `rail_hi` is first sampled high, `sw_en` is 1 and `bias_en` is 0.
- R3: `sw_en` and `bias_en` are never high in the same cycle.
- R4: During normal switching, `rail_lo` sampled high gives `sw_en`=0 and `bias_en`=1 in the next cycle (charging). `reg_lost` sampled high with `rail_lo` low gives `sw_en`=0 and `bias_en`=0 (discharging). `rail_lo` takes priority over `reg_lost`.
- R5: In auto-restart, the bias source follows the rail hysteretically. While discharging, `bias_en` stays 0 until `rail_lo` is sampled, and it is 1 from the next cycle. While charging, it stays 1 until `rail_hi` is sampled, and it is 0 from the next cycle. `rail_hi` wins when both flags are high. `reg_lost` has no effect in these phases.
- R6: Switching is retried only on the SKIP_CYCLES-th (default 8) `rail_hi` crossing after auto-restart is entered. That crossing gives `sw_en`=1 in the next cycle. With `reg_lost` held high, `sw_en` is high for exactly one cycle in every eight discharge-charge cycles.
- R7: If `reg_lost` is low during a retry, switching continues. The skip count restarts from zero, so a later fault again needs the full eight cycles before the next retry.
- R8: An `ov_pulse` sampled high, even for one cycle, gives `sw_en`=0 from the next cycle. The output stays 0 whatever the rail and regulation flags do, until a power-up reset.
- R9: An `ot_flag` sampled high latches shutdown in the same way as R8, through a separate latch.
- R10: While latched off, `bias_en` is 0 on entry. It turns 1 the cycle after `rail_lo` is sampled and turns 0 the cycle after `rail_hi` is sampled.
- R11: `por` overrides all other inputs. A fault flag sampled in the same cycle as `por` sets no latch, so the block then goes through start-up and reaches normal switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por | input | 1 | Power-up reset; clears the fault latches and restarts the sequence |
| rail_hi | input | 1 | Rail at or above the upper threshold |
| rail_lo | input | 1 | Rail at or below the lower threshold |
| ov_pulse | input | 1 | Overvoltage indication (high-current pulse) |
| ot_flag | input | 1 | Junction temperature above the shutdown limit |
| reg_lost | input | 1 | Output regulation lost |
| bias_en | output | 1 | Bias current source enable |
| sw_en | output | 1 | Modulator and output switch enable |

## Verification
The central corner case is the skip count. With regulation held lost over several rounds, the bench counts the retry windows. A counter that is off by one, wraps early or never clears would retry on the seventh or ninth crossing, or straight after a good retry, and the bench would see it. The bench also drives both rail flags high at once and pulses `rail_lo` during start-up: a design with the wrong priority or missing gating would charge when it should discharge, or start switching too early. Each fault cause is tested on its own with one-cycle pulses, followed by rail activity and a release of regulation loss. A latch that decays or is shared would let switching resume, and a latched state that never toggles the bias source would leave the rail uncharged. Finally, `por` is asserted together with faults to show that reset wins and no latch is left set.

// File: rtl/hrs_pkg.sv
package hrs_pkg;

    typedef enum logic [2:0] {
        ST_RESET        = 3'd0,
        ST_STARTUP      = 3'd1,
        ST_NORMAL       = 3'd2,
        ST_AR_DISCHARGE = 3'd3,
        ST_AR_CHARGE    = 3'd4,
        ST_LATCHED      = 3'd5
    } sup_state_e;

    localparam int unsigned FAULT_OV   = 0;
    localparam int unsigned FAULT_OT   = 1;
    localparam int unsigned NUM_FAULTS = 2;

    typedef struct packed {
        logic rail_hi;
        logic rail_lo;
        logic reg_lost;
    } rail_flags_t;

    typedef struct packed {
        logic bias_en;
        logic sw_en;
    } drive_t;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic drive_t decode_drive(input sup_state_e st, input logic lat_chg);
        drive_t d;
        d.sw_en   = (st == ST_NORMAL);
        d.bias_en = (st == ST_STARTUP) || (st == ST_AR_CHARGE) ||
                    ((st == ST_LATCHED) && lat_chg);
        return d;
    endfunction

endpackage

// File: rtl/hrs_fault_latch.sv
module hrs_fault_latch #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] q,
    output logic         any_o
);
    logic [N-1:0] live;

    for (genvar i = 0; i < N; i++) begin : g_latch
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                q[i] <= 1'b0;
            end else if (set[i]) begin
                q[i] <= 1'b1;
            end
        end
        assign live[i] = q[i] || (set[i] && !clr);
    end

    assign any_o = |live;
endmodule

// File: rtl/hrs_skip_counter.sv
module hrs_skip_counter #(
    parameter int unsigned SKIP_CYCLES = 8,
    localparam int unsigned CW = hrs_pkg::cnt_width(SKIP_CYCLES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          inc,
    output logic [CW-1:0] cnt,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (inc && !last) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == CW'(SKIP_CYCLES - 1));
endmodule

// File: rtl/hrs_fsm.sv
module hrs_fsm
    import hrs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  rail_flags_t flags,
    input  logic        fault_any,
    input  logic        skip_last,
    output sup_state_e  state_q,
    output logic        lat_chg_q,
    output logic        cnt_inc,
    output logic        cnt_clear
);
    sup_state_e state_d;
    logic       lat_chg_d;

    always_comb begin
        state_d = state_q;
        if (por) begin
            state_d = ST_RESET;
        end else if (fault_any) begin
            state_d = ST_LATCHED;
        end else begin
            case (state_q)
                ST_RESET:        state_d = ST_STARTUP;
                ST_STARTUP:      if (flags.rail_hi) state_d = ST_NORMAL;
                ST_NORMAL: begin
                    if (flags.rail_lo)       state_d = ST_AR_CHARGE;
                    else if (flags.reg_lost) state_d = ST_AR_DISCHARGE;
                end
                ST_AR_DISCHARGE: if (flags.rail_lo) state_d = ST_AR_CHARGE;
                ST_AR_CHARGE: begin
                    if (flags.rail_hi) state_d = skip_last ? ST_NORMAL : ST_AR_DISCHARGE;
                end
                ST_LATCHED:      state_d = ST_LATCHED;
                default:         state_d = ST_RESET;
            endcase
        end
    end

    always_comb begin
        lat_chg_d = 1'b0;
        if ((state_q == ST_LATCHED) && (state_d == ST_LATCHED)) begin
            if (flags.rail_hi)      lat_chg_d = 1'b0;
            else if (flags.rail_lo) lat_chg_d = 1'b1;
            else                    lat_chg_d = lat_chg_q;
        end
    end

    assign cnt_inc   = (state_q == ST_AR_CHARGE) && flags.rail_hi && !por && !fault_any;
    assign cnt_clear = por || (state_q == ST_NORMAL) || (state_q == ST_RESET) ||
                       (state_q == ST_STARTUP) || (state_q == ST_LATCHED);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_RESET;
            lat_chg_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            lat_chg_q <= lat_chg_d;
        end
    end
endmodule

// File: rtl/hyst_restart_sup.sv
module hyst_restart_sup
    import hrs_pkg::*;
#(
    parameter int unsigned SKIP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic rail_hi,
    input  logic rail_lo,
    input  logic ov_pulse,
    input  logic ot_flag,
    input  logic reg_lost,
    output logic bias_en,
    output logic sw_en
);
    localparam int unsigned CW = cnt_width(SKIP_CYCLES);

    rail_flags_t           flags;
    logic [NUM_FAULTS-1:0] fault_set;
    logic [NUM_FAULTS-1:0] fault_q;
    logic                  fault_any;
    logic [CW-1:0]         skip_cnt;
    logic                  skip_last;
    logic                  cnt_inc;
    logic                  cnt_clear;
    sup_state_e            state_q;
    logic                  lat_chg_q;
    drive_t                drv;

    assign flags.rail_hi  = rail_hi;
    assign flags.rail_lo  = rail_lo;
    assign flags.reg_lost = reg_lost;

    assign fault_set[FAULT_OV] = ov_pulse;
    assign fault_set[FAULT_OT] = ot_flag;

    hrs_fault_latch #(.N(NUM_FAULTS)) u_fault (
        .clk   (clk),
        .rst   (rst),
        .clr   (por),
        .set   (fault_set),
        .q     (fault_q),
        .any_o (fault_any)
    );

    hrs_skip_counter #(.SKIP_CYCLES(SKIP_CYCLES)) u_skip (
        .clk   (clk),
        .rst   (rst),
        .clear (cnt_clear),
        .inc   (cnt_inc),
        .cnt   (skip_cnt),
        .last  (skip_last)
    );

    hrs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .por       (por),
        .flags     (flags),
        .fault_any (fault_any),
        .skip_last (skip_last),
        .state_q   (state_q),
        .lat_chg_q (lat_chg_q),
        .cnt_inc   (cnt_inc),
        .cnt_clear (cnt_clear)
    );

    assign drv     = decode_drive(state_q, lat_chg_q);
    assign bias_en = drv.bias_en;
    assign sw_en   = drv.sw_en;
endmodule

// File: rtl/hrs_checker.sv
module hrs_checker
    import hrs_pkg::*;
#(
    parameter int unsigned SKIP_CYCLES = 8,
    localparam int unsigned CW = cnt_width(SKIP_CYCLES)
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  por,
    input logic                  rail_hi,
    input logic                  rail_lo,
    input logic                  ov_pulse,
    input logic                  ot_flag,
    input logic                  bias_en,
    input logic                  sw_en,
    input sup_state_e            state,
    input logic [CW-1:0]         skip_cnt,
    input logic [NUM_FAULTS-1:0] fault_q
);
    p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(sw_en && bias_en));

    p_por_idle_r1: assert property (@(posedge clk) disable iff (rst)
        por |=> (!sw_en && !bias_en));

    p_ov_off_r8: assert property (@(posedge clk) disable iff (rst)
        (ov_pulse && !por) |=> !sw_en);

    p_ot_off_r9: assert property (@(posedge clk) disable iff (rst)
        (ot_flag && !por) |=> !sw_en);

    p_latch_hold_r8: assert property (@(posedge clk) disable iff (rst)
        ((fault_q != '0) && !por) |=> !sw_en);

    p_startup_go_r2: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_STARTUP) && rail_hi && !por && !ov_pulse && !ot_flag &&
         (fault_q == '0)) |=> sw_en);

    p_retry_count_r6: assert property (@(posedge clk) disable iff (rst)
        ($rose(sw_en) && ($past(state) == ST_AR_CHARGE)) |->
        ($past(skip_cnt) == CW'(SKIP_CYCLES - 1)));

    p_ar_charge_r5: assert property (@(posedge clk) disable iff (rst)
        ((state == ST_AR_DISCHARGE) && rail_lo && !por && !ov_pulse && !ot_flag &&
         (fault_q == '0)) |=> bias_en);
endmodule

bind hyst_restart_sup hrs_checker #(.SKIP_CYCLES(SKIP_CYCLES)) u_hrs_checker (
    .clk      (clk),
    .rst      (rst),
    .por      (por),
    .rail_hi  (rail_hi),
    .rail_lo  (rail_lo),
    .ov_pulse (ov_pulse),
    .ot_flag  (ot_flag),
    .bias_en  (bias_en),
    .sw_en    (sw_en),
    .state    (state_q),
    .skip_cnt (skip_cnt),
    .fault_q  (fault_q)
);

// File: tb/test_hyst_restart_sup.sv
`timescale 1ns/1ps
module test_hyst_restart_sup;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por = 1'b0, rail_hi = 1'b0, rail_lo = 1'b0;
    logic ov_pulse = 1'b0, ot_flag = 1'b0, reg_lost = 1'b0;
    logic bias_en, sw_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    hyst_restart_sup i_hyst_restart_sup (
        .clk(clk), .rst(rst), .por(por), .rail_hi(rail_hi), .rail_lo(rail_lo),
        .ov_pulse(ov_pulse), .ot_flag(ot_flag), .reg_lost(reg_lost),
        .bias_en(bias_en), .sw_en(sw_en)
    );

    // Vector bits: por hi lo ov ot rl | exp_sw exp_bias
    localparam int NV = 12;
    localparam logic [7:0] VEC [NV] = '{
        8'b1_0_0_0_0_0_0_0,  // R1 por -> idle
        8'b0_0_0_0_0_0_0_1,  // R1 start-up charging
        8'b0_0_1_0_0_0_0_1,  // R2 rail_lo ignored in start-up
        8'b0_1_0_0_0_0_1_0,  // R2 first upper crossing -> switching
        8'b0_0_0_0_0_0_1_0,  // R2 stays switching
        8'b0_0_1_0_0_0_0_1,  // R4 rail_lo -> charging
        8'b0_0_0_0_0_0_0_1,  // R5 keeps charging
        8'b0_1_0_0_0_0_0_0,  // R5 upper -> discharging
        8'b0_0_0_0_0_1_0_0,  // R5 reg_lost no effect while discharging
        8'b0_0_1_0_0_0_0_1,  // R5 lower -> charging
        8'b0_1_1_0_0_0_0_0,  // R5 both flags: upper wins
        8'b0_0_1_0_0_0_0_1   // R5 lower -> charging
    };

    task automatic cyc(input logic p, input logic hi, input logic lo,
                       input logic ov, input logic ot, input logic rl);
        por = p; rail_hi = hi; rail_lo = lo; ov_pulse = ov; ot_flag = ot; reg_lost = rl;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic exp_sw, input logic exp_bias);
        checks++;
        if (sw_en !== exp_sw || bias_en !== exp_bias) begin
            errors++;
            $display("FAIL %s: sw_en=%b bias_en=%b expected sw_en=%b bias_en=%b",
                     req, sw_en, bias_en, exp_sw, exp_bias);
        end
    endtask

    task automatic bring_up();
        cyc(1, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int windows;
        @(negedge clk);
        @(negedge clk);
        check("R1 reset", 1'b0, 1'b0);
        rst = 1'b0;
        cyc(0, 0, 0, 0, 0, 0);
        check("R1 start-up after reset", 1'b0, 1'b1);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i][7], VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2]);
            check($sformatf("table row %0d", i), VEC[i][1], VEC[i][0]);
        end

        // R6: repeated auto-restart with regulation held lost
        bring_up();
        check("R2 bring-up", 1'b1, 1'b0);
        cyc(0, 0, 0, 0, 0, 1);
        check("R4 reg_lost -> discharging", 1'b0, 1'b0);
        windows = 0;
        for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 8; k++) begin
                cyc(0, 0, 1, 0, 0, 1);
                check("R5 lower -> charge", 1'b0, 1'b1);
                cyc(0, 1, 0, 0, 0, 1);
                if (sw_en) windows++;
                if (k < 7) check("R6 no early retry", 1'b0, 1'b0);
                else       check("R6 retry on eighth crossing", 1'b1, 1'b0);
            end
            if (r < 2) begin
                cyc(0, 0, 0, 0, 0, 1);
                if (sw_en) windows++;
                check("R6 retry lasts one cycle", 1'b0, 1'b0);
            end
        end
        checks++;
        if (windows != 3) begin
            errors++;
            $display("FAIL R6 window count: got %0d expected %0d", windows, 3);
        end

        // R7: regulation back during retry
        for (int k = 0; k < 3; k++) begin
            cyc(0, 0, 0, 0, 0, 0);
            check("R7 stays switching", 1'b1, 1'b0);
        end
        cyc(0, 0, 0, 0, 0, 1);
        check("R7 new fault -> discharging", 1'b0, 1'b0);
        for (int k = 0; k < 8; k++) begin
            cyc(0, 0, 1, 0, 0, 1);
            cyc(0, 1, 0, 0, 0, 1);
            if (k < 7) check("R7 count restarted", 1'b0, 1'b0);
            else       check("R7 retry after eight", 1'b1, 1'b0);
        end

        // R8 and R10: overvoltage latch
        cyc(0, 0, 0, 1, 0, 0);
        check("R8 ov pulse off", 1'b0, 1'b0);
        cyc(0, 1, 0, 0, 0, 0);
        check("R10 latched bias off on entry", 1'b0, 1'b0);
        cyc(0, 0, 1, 0, 0, 0);
        check("R10 latched lower -> bias on", 1'b0, 1'b1);
        cyc(0, 0, 0, 0, 0, 0);
        check("R10 latched holds bias", 1'b0, 1'b1);
        cyc(0, 1, 0, 0, 0, 0);
        check("R10 latched upper -> bias off", 1'b0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            cyc(0, 1, 0, 0, 0, 0);
            check("R8 latch held", 1'b0, 1'b0);
        end
        bring_up();
        check("R8 por clears latch", 1'b1, 1'b0);

        // R9: over-temperature latch
        cyc(0, 0, 0, 0, 1, 0);
        check("R9 ot off", 1'b0, 1'b0);
        cyc(0, 0, 1, 0, 0, 0);
        check("R9 latched lower", 1'b0, 1'b1);
        cyc(0, 1, 0, 0, 0, 0);
        check("R9 latched upper", 1'b0, 1'b0);
        cyc(0, 1, 0, 0, 0, 0);
        check("R9 latch held", 1'b0, 1'b0);
        bring_up();
        check("R9 por clears latch", 1'b1, 1'b0);

        // R11: por wins over faults in the same cycle
        cyc(1, 1, 0, 1, 1, 1);
        check("R11 por idle", 1'b0, 1'b0);
        cyc(0, 0, 0, 0, 0, 0);
        check("R11 start-up, no latch", 1'b0, 1'b1);
        cyc(0, 1, 0, 0, 0, 0);
        check("R11 reaches switching", 1'b1, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule